// File: doc/BRIEF.md
# Asynchronous Serial Sequence Trigger

This block listens, without driving anything, to one asynchronous serial line. It rebuilds each character frame from the line and compares the received characters with a programmed sequence of one to four bytes. When the whole sequence has arrived in consecutive frames, it emits a single-cycle trigger pulse. The pulse lands inside the stop bit of the final character, not later when the character is handed over.

Frame timing comes from a divisor that sets an oversampling tick at sixteen ticks per bit. The character length is 7 or 8 data bits, sent least significant bit first after a low start bit. An optional even or odd parity bit may follow the data, before a high stop bit. Each pattern byte has its own mask, so individual bits can be excluded from the comparison. The most recent character and a per-frame error flag are also presented at the outputs.

Top module: `uart_seq_trigger`

## Requirements
- R1: After reset, `trig_o` is 0, `rx_err_o` is 0 and `rx_byte_o` is 0x00.
- R2: In 8-bit mode (`data8_i`=1), the eight data bits that follow the start bit, first bit = bit 0, appear on `rx_byte_o` once the frame ends. `rx_byte_o` changes only at frame ends.
- R3: In 7-bit mode (`data8_i`=0), seven data bits are received and `rx_byte_o[7]` is 0.
- R4: `parity_mode_i` is 0 for none, 1 for even, 2 for odd and 3 for none. A parity bit that does not match sets `rx_err_o` for that frame, suppresses the trigger and returns the matcher to the first pattern byte.
- R5: A stop bit sampled low sets `rx_err_o` for that frame, suppresses the trigger and returns the matcher to the first pattern byte. The next good frame clears `rx_err_o`.
- R6: A low pulse shorter than half a bit on the idle line is rejected at the start-bit midpoint and produces no frame.
- R7: Pattern byte k is `pat_value_i[8k+7:8k]` with mask `pat_mask_i[8k+7:8k]`. A mask bit of 0 excludes that data bit from the comparison.
- R8: With `pat_len_i`=0, a frame that matches byte 0 produces exactly one `trig_o` pulse of one cycle. The pulse lies within the stop-bit period of that frame.
- R9: With `pat_len_i`=n, the trigger fires only after n+1 consecutive error-free frames match pattern bytes 0..n in order. It fires within the stop bit of the last of those frames, after which matching starts again from byte 0.
- R10: A frame that breaks a partly matched sequence is compared again with pattern byte 0 and, if it matches, counts as the first byte of a new sequence.
- R11: An oversampling tick occurs every `baud_div_i`+1 clock cycles, and one bit lasts 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Monitored serial line, idle high |
| baud_div_i | input | 16 | Oversampling tick divisor minus one |
| data8_i | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| parity_mode_i | input | 2 | 0/3 none, 1 even, 2 odd |
| pat_len_i | input | 2 | Pattern length minus one |
| pat_value_i | input | 32 | Four compare bytes, byte k at bits 8k+7:8k |
| pat_mask_i | input | 32 | Four compare masks, 0 = don't care |
| trig_o | output | 1 | One-cycle trigger pulse |
| rx_byte_o | output | 8 | Last received character |
| rx_err_o | output | 1 | Framing or parity error on the last frame |

## Verification
The assertions check on every cycle that a trigger lasts exactly one cycle and always follows an internal end-of-frame strobe. They also check that a trigger never coincides with an error flag, that the byte and error outputs move only at frame ends, and that bit 7 is cleared in 7-bit mode. The bench scenarios are the only way to show sequence ordering, restart after a broken sequence, masking, parity polarity, glitch rejection, and that the pulse falls inside the stop bit at more than one divisor.

// File: rtl/uart_trig_pkg.sv
package uart_trig_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_t;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  typedef struct packed {
    logic [7:0] data;
    logic       err;
  } frame_t;
endpackage

// File: rtl/uart_trig_sync.sv
module uart_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_n;

  always_comb begin
    sr_n = {sr_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '1;
    else        sr_q <= sr_n;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_trig_tick.sv
module uart_trig_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_n;
  logic             wrap;

  assign wrap = (cnt_q >= div_i);

  always_comb begin
    cnt_n = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/uart_trig_rx.sv
module uart_trig_rx
  import uart_trig_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       rx_s_i,
  input  logic       data8_i,
  input  logic [1:0] par_mode_i,
  output logic       done_o,
  output frame_t     frame_o
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_t   state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]  bit_q, bit_n;
  logic [7:0]  sh_q, sh_n;
  logic        acc_q, acc_n;
  logic        perr_q, perr_n;
  logic        done_q, done_n;
  frame_t      frm_q, frm_n;
  logic        par_en;
  logic [2:0]  last_bit;

  assign par_en   = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
  assign last_bit = data8_i ? 3'd7 : 3'd6;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    acc_n   = acc_q;
    perr_n  = perr_q;
    done_n  = 1'b0;
    frm_n   = frm_q;
    case (state_q)
      ST_IDLE: begin
        if (tick_i && !rx_s_i) begin
          state_n = ST_START;
          cnt_n   = '0;
        end
      end
      ST_START: begin
        if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_n  = '0;
            bit_n  = '0;
            acc_n  = 1'b0;
            perr_n = 1'b0;
            state_n = rx_s_i ? ST_IDLE : ST_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_n        = '0;
            sh_n[bit_q]  = rx_s_i;
            acc_n        = acc_q ^ rx_s_i;
            if (bit_q == last_bit) state_n = par_en ? ST_PARITY : ST_STOP;
            else                   bit_n   = bit_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_PARITY: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_n   = '0;
            perr_n  = rx_s_i ^ acc_q ^ (par_mode_i == PAR_ODD);
            state_n = ST_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_STOP: begin
        if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_n      = '0;
            done_n     = 1'b1;
            frm_n.data = data8_i ? sh_q : {1'b0, sh_q[6:0]};
            frm_n.err  = perr_q | ~rx_s_i;
            state_n    = ST_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
      frm_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      sh_q    <= sh_n;
      acc_q   <= acc_n;
      perr_q  <= perr_n;
      done_q  <= done_n;
      frm_q   <= frm_n;
    end
  end

  assign done_o  = done_q;
  assign frame_o = frm_q;
endmodule

// File: rtl/uart_trig_match.sv
module uart_trig_match
  import uart_trig_pkg::*;
#(
  parameter int MAX_PAT = 4,
  localparam int IW = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  frame_t               frame_i,
  input  logic [IW-1:0]        pat_len_i,
  input  logic [MAX_PAT*8-1:0] pat_value_i,
  input  logic [MAX_PAT*8-1:0] pat_mask_i,
  output logic                 trig_o,
  output logic [7:0]           byte_o,
  output logic                 err_o
);
  logic [MAX_PAT-1:0] hit;
  logic [IW-1:0]      idx_q, idx_n;
  logic               trig_q, trig_n;
  logic [7:0]         byte_q, byte_n;
  logic               err_q, err_n;

  for (genvar k = 0; k < MAX_PAT; k++) begin : g_cmp
    assign hit[k] = (((frame_i.data ^ pat_value_i[8*k +: 8]) & pat_mask_i[8*k +: 8]) == 8'h00);
  end

  always_comb begin
    idx_n  = idx_q;
    trig_n = 1'b0;
    byte_n = byte_q;
    err_n  = err_q;
    if (done_i) begin
      byte_n = frame_i.data;
      err_n  = frame_i.err;
      if (frame_i.err) begin
        idx_n = '0;
      end else if (hit[idx_q]) begin
        if (idx_q >= pat_len_i) begin
          trig_n = 1'b1;
          idx_n  = '0;
        end else begin
          idx_n = idx_q + 1'b1;
        end
      end else if (hit[0]) begin
        if (pat_len_i == '0) begin
          trig_n = 1'b1;
          idx_n  = '0;
        end else begin
          idx_n = IW'(1);
        end
      end else begin
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      trig_q <= 1'b0;
      byte_q <= '0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      trig_q <= trig_n;
      byte_q <= byte_n;
      err_q  <= err_n;
    end
  end

  assign trig_o = trig_q;
  assign byte_o = byte_q;
  assign err_o  = err_q;
endmodule

// File: rtl/uart_seq_trigger.sv
module uart_seq_trigger
  import uart_trig_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int OVS     = 16,
  parameter int MAX_PAT = 4,
  parameter int SYNC    = 2,
  localparam int IW = (MAX_PAT > 1) ? $clog2(MAX_PAT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  input  logic [DIV_W-1:0]     baud_div_i,
  input  logic                 data8_i,
  input  logic [1:0]           parity_mode_i,
  input  logic [IW-1:0]        pat_len_i,
  input  logic [MAX_PAT*8-1:0] pat_value_i,
  input  logic [MAX_PAT*8-1:0] pat_mask_i,
  output logic                 trig_o,
  output logic [7:0]           rx_byte_o,
  output logic                 rx_err_o
);
  logic   rx_s;
  logic   tick;
  logic   frm_done;
  frame_t frm;

  uart_trig_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  uart_trig_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_i(baud_div_i), .tick_o(tick)
  );

  uart_trig_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_s_i(rx_s),
    .data8_i(data8_i), .par_mode_i(parity_mode_i),
    .done_o(frm_done), .frame_o(frm)
  );

  uart_trig_match #(.MAX_PAT(MAX_PAT)) u_match (
    .clk(clk), .rst_n(rst_n), .done_i(frm_done), .frame_i(frm),
    .pat_len_i(pat_len_i), .pat_value_i(pat_value_i), .pat_mask_i(pat_mask_i),
    .trig_o(trig_o), .byte_o(rx_byte_o), .err_o(rx_err_o)
  );
endmodule

// File: rtl/uart_trig_chk.sv
module uart_trig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_o,
  input logic [7:0] rx_byte_o,
  input logic       rx_err_o,
  input logic       frm_done,
  input logic       data8_i
);
  assert_trig_after_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> $past(frm_done));

  assert_trig_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  assert_no_trig_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !rx_err_o);

  assert_byte_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frm_done) |-> ($stable(rx_byte_o) && $stable(rx_err_o)));

  assert_seven_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && !data8_i) |=> !rx_byte_o[7]);
endmodule

bind uart_seq_trigger uart_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .rx_byte_o(rx_byte_o),
  .rx_err_o(rx_err_o), .frm_done(frm_done), .data8_i(data8_i)
);

// File: tb/uart_seq_trigger_bench.sv
`timescale 1ns/1ps
module uart_seq_trigger_bench;
  logic        clk;
  logic        rst_n;
  logic        rx;
  logic [15:0] div;
  logic        d8;
  logic [1:0]  pmode;
  logic [1:0]  plen;
  logic [31:0] pval;
  logic [31:0] pmask;
  logic        trig;
  logic [7:0]  rbyte;
  logic        rerr;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int trig_cnt = 0;
  int trig_cyc = 0;
  int t0 = 0;
  int seen = 0;

  uart_seq_trigger u_uart_seq_trigger (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .baud_div_i(div), .data8_i(d8),
    .parity_mode_i(pmode), .pat_len_i(plen), .pat_value_i(pval),
    .pat_mask_i(pmask), .trig_o(trig), .rx_byte_o(rbyte), .rx_err_o(rerr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && trig) begin
      trig_cnt = trig_cnt + 1;
      trig_cyc = cyc;
    end
  end

  // {expected trigger, byte}; pattern 5A then C3, full masks (R9, R10, R2)
  localparam logic [8:0] VEC [10] = '{
    9'h05A, 9'h1C3, 9'h0C3, 9'h05A, 9'h05A,
    9'h1C3, 9'h011, 9'h05A, 9'h011, 9'h0C3
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_wait(input int n);
    repeat (n * 16 * (div + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    int nb;
    logic p;
    nb = d8 ? 8 : 7;
    p  = 1'b0;
    @(negedge clk);
    t0 = cyc;
    rx = 1'b0;
    bit_wait(1);
    for (int i = 0; i < nb; i++) begin
      rx = b[i];
      p  = p ^ b[i];
      bit_wait(1);
    end
    if (pmode == 2'd1 || pmode == 2'd2) begin
      rx = (pmode == 2'd2) ? ~p : p;
      if (bad_par) rx = ~rx;
      bit_wait(1);
    end
    rx = bad_stop ? 1'b0 : 1'b1;
    bit_wait(1);
    rx = 1'b1;
    bit_wait(2);
  endtask

  task automatic frame_chk(input string req, input bit exp_trig,
                           input logic [7:0] exp_byte, input bit exp_err);
    int sb, bp, off;
    sb  = 1 + (d8 ? 8 : 7) + ((pmode == 2'd1 || pmode == 2'd2) ? 1 : 0);
    bp  = 16 * (div + 1);
    check(trig_cnt - seen == int'(exp_trig), {req, " trigger count"}, trig_cnt - seen, int'(exp_trig));
    if (exp_trig && trig_cnt - seen == 1) begin
      off = trig_cyc - t0;
      check(off >= sb * bp && off < (sb + 1) * bp, {req, " trigger in stop bit"}, off, sb * bp);
    end
    check(rbyte == exp_byte, {req, " byte"}, rbyte, exp_byte);
    check(rerr == exp_err, {req, " error flag"}, rerr, exp_err);
    seen = trig_cnt;
  endtask

  initial begin
    rx = 1'b1; div = 16'd0; d8 = 1'b1; pmode = 2'd0; plen = 2'd1;
    pval = 32'h0000_C35A; pmask = 32'h0000_FFFF;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(trig == 1'b0 && rerr == 1'b0 && rbyte == 8'h00, "R1 reset outputs", {trig, rerr, rbyte}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table: R2, R9, R10, R8 window
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][7:0], 1'b0, 1'b0);
      frame_chk("R9/R10 table", VEC[i][8], VEC[i][7:0], 1'b0);
    end

    // R5 framing error mid-sequence resets matcher
    send(8'h5A, 1'b0, 1'b0);
    frame_chk("R5 first byte", 1'b0, 8'h5A, 1'b0);
    send(8'hC3, 1'b0, 1'b1);
    frame_chk("R5 bad stop", 1'b0, 8'hC3, 1'b1);
    send(8'hC3, 1'b0, 1'b0);
    frame_chk("R5 after error", 1'b0, 8'hC3, 1'b0);

    // R6 glitch rejection
    @(negedge clk);
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    bit_wait(12);
    check(rbyte == 8'hC3 && trig_cnt == seen, "R6 glitch ignored", rbyte, 8'hC3);
    send(8'h5A, 1'b0, 1'b0);
    frame_chk("R6 frame after glitch", 1'b0, 8'h5A, 1'b0);
    send(8'hC3, 1'b0, 1'b0);
    frame_chk("R6 sequence after glitch", 1'b1, 8'hC3, 1'b0);

    // R3 7-bit mode, R4 parity
    d8 = 1'b0; pmode = 2'd1; plen = 2'd0; pval = 32'h35; pmask = 32'hFF;
    send(8'hB5, 1'b0, 1'b0);
    frame_chk("R3 seven bit even", 1'b1, 8'h35, 1'b0);
    send(8'h35, 1'b1, 1'b0);
    frame_chk("R4 even parity error", 1'b0, 8'h35, 1'b1);
    pmode = 2'd2;
    send(8'h35, 1'b0, 1'b0);
    frame_chk("R4 odd parity good", 1'b1, 8'h35, 1'b0);
    send(8'h35, 1'b1, 1'b0);
    frame_chk("R4 odd parity error", 1'b0, 8'h35, 1'b1);

    // R7 mask
    d8 = 1'b1; pmode = 2'd3; pval = 32'hA0; pmask = 32'hF0;
    send(8'hAF, 1'b0, 1'b0);
    frame_chk("R7 masked match", 1'b1, 8'hAF, 1'b0);
    send(8'hBF, 1'b0, 1'b0);
    frame_chk("R7 unmasked mismatch", 1'b0, 8'hBF, 1'b0);

    // R11 divisor, R8 window at slower rate
    div = 16'd2; pmode = 2'd0; pval = 32'h3C; pmask = 32'hFF;
    bit_wait(1);
    send(8'h3C, 1'b0, 1'b0);
    frame_chk("R11 divided rate", 1'b1, 8'h3C, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_200_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule